// File: doc/BRIEF.md
# SDRAM Read Burst Wrap Splitter

This block turns one incrementing read request from a 32-bit system bus into the column read commands that a memory controller sends to an SDRAM. The SDRAM always runs a fixed burst of 8 column locations. Such a burst stays inside an aligned group of 8 columns and wraps back to the start of that group. A bus burst that starts partway into a group and needs more words than remain in it would otherwise receive wrapped data. The splitter detects this case and issues a further read command at the base of the next aligned group. Every command carries a flag that marks it for early termination by a burst stop, so that no unneeded words are fetched past the last requested one.

Two memory widths are supported. With a 16-bit DDR device a group holds 16 bytes, which is 4 bus words. With a 32-bit SDR device a group holds 32 bytes, which is 8 bus words. Commands leave the block through a valid/ready handshake. A new bus request is taken only after the last command of the current request has been accepted. A read of undefined length is presented one beat per request. The block issues one command each time such a beat enters a new group.

Top module: `rd_wrap_splitter`

## Requirements
- R1: After synchronous reset, cmd_valid is 0 and req_ready is 1.
- R2: A request whose words all fit in the group of its start address yields exactly one command, at the start address, with cmd_beats equal to the request length and cmd_last = 1. The request kind codes are 0 = single (1 word), 1 = undefined-length beat, 2 = 4 words, 3 = 8 words and 4 = 16 words. Addresses are word aligned, so bits 1:0 are 0.
- R3: For DDR (req_sdr = 0, 16-byte groups), a 4-word request that starts at byte offset 0x4, 0x8 or 0xC within its group yields two commands. The first covers the words up to the group end. The second starts at the next 16-byte aligned address and carries the rest.
- R4: For SDR (req_sdr = 1, 32-byte groups), a 4-word request that starts at byte offset 0x14, 0x18 or 0x1C yields two commands. The second starts at the next 32-byte aligned address. Offsets 0x00 to 0x10 yield one command.
- R5: A longer request yields one command per group it touches, in address order. Every command after the first starts on a group boundary. Commands that are neither first nor last carry a full group of words (4 for DDR, 8 for SDR).
- R6: cmd_stop is 1 exactly when cmd_beats is less than the words per group (4 for DDR, 8 for SDR).
- R7: While cmd_valid is 1 and cmd_ready is 0, all command outputs hold their values.
- R8: req_ready is 0 whenever cmd_valid is 1. It returns to 1 in the cycle after the command with cmd_last = 1 is accepted.
- R9: An undefined-length beat (kind 1) issues a command that covers its word to the end of the group. A following kind-1 beat in the same group and memory type issues no command. Any other kind ends that run.
- R10: cmd_col is the byte address shifted right by 1 for DDR and by 2 for SDR, truncated to COLW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | AW | Byte start address, word aligned |
| req_kind | input | 3 | Burst kind code (see R2) |
| req_sdr | input | 1 | 1 = SDR device, 0 = DDR device |
| cmd_valid | output | 1 | Read command present |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_addr | output | AW | Byte address of the first needed word |
| cmd_col | output | COLW | Device column address |
| cmd_beats | output | CNTW | Bus words used from this command |
| cmd_stop | output | 1 | Terminate this burst with a burst stop |
| cmd_last | output | 1 | Final command of the request |

## Verification
On every cycle the assertions check that a command never spans past the end of its group and that commands stay stable while stalled. They also check that every continuation command lands on a group boundary, that the command stream ends after the last command, and that a skipped undefined-length beat starts nothing. Only the bench scenarios can show that the split points, beat counts, stop flags and columns are right for each DDR and SDR start offset. They also show that the undefined-length runs emit exactly the expected commands and no extra ones.

// File: rtl/rws_pkg.sv
package rws_pkg;

  typedef enum logic [2:0] {
    KIND_SINGLE  = 3'd0,
    KIND_OPEN    = 3'd1,
    KIND_BURST4  = 3'd2,
    KIND_BURST8  = 3'd3,
    KIND_BURST16 = 3'd4
  } bus_kind_e;

  // Number of bus words a fixed-length kind asks for.
  function automatic logic [4:0] kind_words(input bus_kind_e k);
    case (k)
      KIND_BURST4:  return 5'd4;
      KIND_BURST8:  return 5'd8;
      KIND_BURST16: return 5'd16;
      default:      return 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/rws_geom.sv
module rws_geom #(
  parameter int AW           = 32,
  parameter int CNTW         = 5,
  parameter int BUS_BYTES    = 4,
  parameter int DDR_DQ_BYTES = 2,
  parameter int SDR_DQ_BYTES = 4,
  parameter int BURST_LEN    = 8
) (
  input  logic [AW-1:0]   addr,
  input  logic            is_sdr,
  output logic [CNTW-1:0] words_per_grp,
  output logic [CNTW-1:0] word_idx,
  output logic [AW-1:0]   grp_bytes,
  output logic [AW-1:0]   next_base,
  output logic [AW-1:0]   grp_tag
);
  localparam int DDR_GRP = BURST_LEN * DDR_DQ_BYTES;
  localparam int SDR_GRP = BURST_LEN * SDR_DQ_BYTES;
  localparam int DDR_WPG = DDR_GRP / BUS_BYTES;
  localparam int SDR_WPG = SDR_GRP / BUS_BYTES;
  localparam int DDR_GSH = $clog2(DDR_GRP);
  localparam int SDR_GSH = $clog2(SDR_GRP);
  localparam int BSH     = $clog2(BUS_BYTES);

  logic [AW-1:0] mask;
  logic [AW-1:0] offs;
  logic [AW-1:0] base;

  always_comb begin
    grp_bytes     = is_sdr ? AW'(SDR_GRP) : AW'(DDR_GRP);
    words_per_grp = is_sdr ? CNTW'(SDR_WPG) : CNTW'(DDR_WPG);
    mask          = grp_bytes - AW'(1);
    offs          = addr & mask;
    base          = addr & ~mask;
    word_idx      = CNTW'(offs >> BSH);
    next_base     = base + grp_bytes;
    grp_tag       = is_sdr ? (addr >> SDR_GSH) : (addr >> DDR_GSH);
  end
endmodule

// File: rtl/rws_open_track.sv
module rws_open_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          is_open,
  input  logic [AW-1:0] tag,
  input  logic          sdr,
  output logic          hit
);
  logic          open_q;
  logic [AW-1:0] tag_q;
  logic          sdr_q;

  assign hit = is_open && open_q && (tag == tag_q) && (sdr == sdr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      tag_q  <= '0;
      sdr_q  <= 1'b0;
    end else if (accept) begin
      open_q <= is_open;
      tag_q  <= tag;
      sdr_q  <= sdr;
    end
  end
endmodule

// File: rtl/rws_seq.sv
module rws_seq #(
  parameter int AW           = 32,
  parameter int COLW         = 12,
  parameter int CNTW         = 5,
  parameter int BUS_BYTES    = 4,
  parameter int DDR_DQ_BYTES = 2,
  parameter int SDR_DQ_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [AW-1:0]   ld_addr,
  input  logic            ld_sdr,
  input  logic [CNTW-1:0] ld_total,
  input  logic [CNTW-1:0] ld_first,
  input  logic [CNTW-1:0] ld_wpg,
  input  logic [AW-1:0]   ld_next,
  input  logic [AW-1:0]   ld_gbytes,
  input  logic            cmd_ready,
  output logic            cmd_valid,
  output logic [AW-1:0]   cmd_addr,
  output logic [COLW-1:0] cmd_col,
  output logic [CNTW-1:0] cmd_beats,
  output logic            cmd_stop,
  output logic            cmd_last
);
  localparam int DDR_CSH = $clog2(DDR_DQ_BYTES);
  localparam int SDR_CSH = $clog2(SDR_DQ_BYTES);
  localparam int BSH     = $clog2(BUS_BYTES);

  function automatic logic [COLW-1:0] col_of(input logic [AW-1:0] a, input logic s);
    return s ? COLW'(a >> SDR_CSH) : COLW'(a >> DDR_CSH);
  endfunction

  logic [CNTW-1:0] remain_q;
  logic [AW-1:0]   next_q;
  logic [AW-1:0]   gbytes_q;
  logic [CNTW-1:0] wpg_q;
  logic            sdr_q;
  logic [CNTW-1:0] take;

  assign take = (remain_q > wpg_q) ? wpg_q : remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_col   <= '0;
      cmd_beats <= '0;
      cmd_stop  <= 1'b0;
      cmd_last  <= 1'b0;
      remain_q  <= '0;
      next_q    <= '0;
      gbytes_q  <= '0;
      wpg_q     <= '0;
      sdr_q     <= 1'b0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_addr  <= ld_addr;
      cmd_col   <= col_of(ld_addr, ld_sdr);
      cmd_beats <= ld_first;
      cmd_stop  <= ld_first < ld_wpg;
      cmd_last  <= ld_total == ld_first;
      remain_q  <= ld_total - ld_first;
      next_q    <= ld_next;
      gbytes_q  <= ld_gbytes;
      wpg_q     <= ld_wpg;
      sdr_q     <= ld_sdr;
    end else if (cmd_valid && cmd_ready) begin
      if (cmd_last) begin
        cmd_valid <= 1'b0;
      end else begin
        cmd_addr  <= next_q;
        cmd_col   <= col_of(next_q, sdr_q);
        cmd_beats <= take;
        cmd_stop  <= take < wpg_q;
        cmd_last  <= remain_q == take;
        remain_q  <= remain_q - take;
        next_q    <= next_q + gbytes_q;
      end
    end
  end

  // Checks on the outgoing command stream.
  logic [AW-1:0]   chk_offs;
  logic [CNTW-1:0] chk_idx;
  assign chk_offs = cmd_addr & (gbytes_q - AW'(1));
  assign chk_idx  = CNTW'(chk_offs >> BSH);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ((CNTW+1)'(chk_idx) + (CNTW+1)'(cmd_beats) <= (CNTW+1)'(wpg_q)) && (cmd_beats != '0)); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats)
                                   && $stable(cmd_stop) && $stable(cmd_last) && $stable(cmd_col))); // R7
  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !cmd_last) |=> (cmd_valid && chk_offs == '0)); // R5
  AST_END_OF_STREAM: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_last && !load) |=> !cmd_valid); // R8
endmodule

// File: rtl/rd_wrap_splitter.sv
module rd_wrap_splitter
  import rws_pkg::*;
#(
  parameter int AW           = 32,
  parameter int COLW         = 12,
  parameter int MAX_WORDS    = 16,
  parameter int BUS_BYTES    = 4,
  parameter int DDR_DQ_BYTES = 2,
  parameter int SDR_DQ_BYTES = 4,
  parameter int BURST_LEN    = 8,
  localparam int CNTW        = $clog2(MAX_WORDS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [2:0]      req_kind,
  input  logic            req_sdr,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [AW-1:0]   cmd_addr,
  output logic [COLW-1:0] cmd_col,
  output logic [CNTW-1:0] cmd_beats,
  output logic            cmd_stop,
  output logic            cmd_last
);
  bus_kind_e       kind;
  logic [CNTW-1:0] wpg, widx, avail, total, first;
  logic [AW-1:0]   gbytes, next_base, tag;
  logic            accept, skip, load, is_open;

  assign kind    = bus_kind_e'(req_kind);
  assign is_open = (kind == KIND_OPEN);

  rws_geom #(
    .AW(AW), .CNTW(CNTW), .BUS_BYTES(BUS_BYTES),
    .DDR_DQ_BYTES(DDR_DQ_BYTES), .SDR_DQ_BYTES(SDR_DQ_BYTES), .BURST_LEN(BURST_LEN)
  ) u_geom (
    .addr(req_addr), .is_sdr(req_sdr), .words_per_grp(wpg), .word_idx(widx),
    .grp_bytes(gbytes), .next_base(next_base), .grp_tag(tag)
  );

  assign req_ready = !cmd_valid;
  assign accept    = req_valid && req_ready;

  rws_open_track #(.AW(AW)) u_track (
    .clk(clk), .rst(rst), .accept(accept), .is_open(is_open),
    .tag(tag), .sdr(req_sdr), .hit(skip)
  );

  always_comb begin
    avail = wpg - widx;
    total = is_open ? avail : CNTW'(kind_words(kind));
    first = (total < avail) ? total : avail;
  end

  assign load = accept && !skip;

  rws_seq #(
    .AW(AW), .COLW(COLW), .CNTW(CNTW), .BUS_BYTES(BUS_BYTES),
    .DDR_DQ_BYTES(DDR_DQ_BYTES), .SDR_DQ_BYTES(SDR_DQ_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst), .load(load), .ld_addr(req_addr), .ld_sdr(req_sdr),
    .ld_total(total), .ld_first(first), .ld_wpg(wpg), .ld_next(next_base),
    .ld_gbytes(gbytes), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_col(cmd_col), .cmd_beats(cmd_beats),
    .cmd_stop(cmd_stop), .cmd_last(cmd_last)
  );

  AST_SKIP_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    (accept && skip) |=> !cmd_valid); // R9
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !(cmd_ready && cmd_last)) |=> !req_ready); // R8
endmodule

// File: tb/rd_wrap_splitter_bench.sv
module rd_wrap_splitter_bench;
  localparam int CLK_NS = 10;
  localparam int AW     = 32;
  localparam int COLW   = 12;
  localparam int CNTW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_kind = '0;
  logic req_sdr = 1'b0;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic [AW-1:0] cmd_addr;
  logic [COLW-1:0] cmd_col;
  logic [CNTW-1:0] cmd_beats;
  logic cmd_stop, cmd_last;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  rd_wrap_splitter #(.AW(AW), .COLW(COLW)) u_rd_wrap_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_sdr(req_sdr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_col(cmd_col), .cmd_beats(cmd_beats), .cmd_stop(cmd_stop), .cmd_last(cmd_last)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [COLW-1:0] col;
    int beats;
    bit stop;
    bit last;
    string tag;
  } exp_t;
  exp_t sb[$];

  bit m_open = 0;
  logic [AW-1:0] m_tag = '0;
  bit m_sdr = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Driver: model the expected commands, then present the request.
  task automatic send(input logic [AW-1:0] a, input int kind, input bit sdr, input string tag);
    int gb, w, idx, avail, total, rem, take;
    logic [AW-1:0] cur, gtag;
    bit first, skip;
    exp_t e;
    gb = sdr ? 32 : 16;
    w = gb / 4;
    idx = int'(a % gb) / 4;
    avail = w - idx;
    case (kind)
      0: total = 1;
      1: total = avail;
      2: total = 4;
      3: total = 8;
      default: total = 16;
    endcase
    gtag = a / gb;
    skip = (kind == 1) && m_open && (m_tag == gtag) && (m_sdr == sdr);
    m_open = (kind == 1);
    m_tag = gtag;
    m_sdr = sdr;
    if (!skip) begin
      cur = a; rem = total; first = 1;
      while (rem > 0) begin
        take = first ? ((rem < avail) ? rem : avail) : ((rem < w) ? rem : w);
        e.a = cur;
        e.col = sdr ? COLW'(cur >> 2) : COLW'(cur >> 1);
        e.beats = take;
        e.stop = (take < w);
        e.last = (rem == take);
        e.tag = tag;
        sb.push_back(e);
        rem -= take;
        cur = (cur / gb) * gb + gb;
        first = 0;
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_kind = 3'(kind); req_sdr = sdr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Downstream ready pattern.
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // Monitor: pop and compare each accepted command.
  bit held = 0;
  exp_t prev;
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      if (cmd_valid)
        check(!req_ready, "R8", "req_ready while command pending", req_ready, 0);
      if (held)
        check(cmd_valid && cmd_addr == prev.a && cmd_beats == CNTW'(prev.beats)
              && cmd_stop == prev.stop && cmd_last == prev.last,
              "R7", "stalled command changed", cmd_addr, prev.a);
      held = 0;
      if (cmd_valid && !cmd_ready) begin
        held = 1;
        prev.a = cmd_addr; prev.beats = int'(cmd_beats);
        prev.stop = cmd_stop; prev.last = cmd_last;
      end
      if (cmd_valid && cmd_ready) begin
        if (sb.size() == 0) begin
          check(0, "R9", "unexpected command addr", cmd_addr, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cmd_addr == e.a, e.tag, "cmd_addr", cmd_addr, e.a);
          check(cmd_beats == CNTW'(e.beats), e.tag, "cmd_beats", cmd_beats, e.beats);
          check(cmd_stop == e.stop, "R6", "cmd_stop", cmd_stop, e.stop);
          check(cmd_last == e.last, e.tag, "cmd_last", cmd_last, e.last);
          check(cmd_col == e.col, "R10", "cmd_col", cmd_col, e.col);
        end
      end
    end
  end

  task automatic drain(input string tag);
    int n = 0;
    while ((sb.size() != 0 || cmd_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    #2;
    check(sb.size() == 0, tag, "commands missing", sb.size(), 0);
    check(req_ready, "R8", "req_ready after last command", req_ready, 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL R8 watchdog expired: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    check(!cmd_valid, "R1", "cmd_valid after reset", cmd_valid, 0);
    check(req_ready, "R1", "req_ready after reset", req_ready, 1);

    // Non-crossing requests (R2)
    send(32'h200, 0, 0, "R2");
    send(32'h300, 2, 0, "R2");
    send(32'h400, 2, 1, "R2");
    send(32'h410, 2, 1, "R4");
    drain("R2");
    // DDR crossing starts (R3)
    send(32'h30C, 2, 0, "R3");
    send(32'h304, 2, 0, "R3");
    send(32'h308, 2, 0, "R3");
    drain("R3");
    // SDR crossing starts (R4)
    send(32'h414, 2, 1, "R4");
    send(32'h418, 2, 1, "R4");
    send(32'h41C, 2, 1, "R4");
    drain("R4");
    // Long bursts (R5)
    send(32'h504, 4, 0, "R5");
    send(32'h61C, 4, 1, "R5");
    send(32'h700, 3, 0, "R5");
    send(32'h808, 3, 1, "R5");
    drain("R5");
    // Undefined-length runs (R9)
    send(32'h100, 1, 0, "R9");
    send(32'h104, 1, 0, "R9");
    send(32'h108, 1, 0, "R9");
    send(32'h10C, 1, 0, "R9");
    send(32'h110, 1, 0, "R9");
    send(32'h114, 0, 0, "R9");
    send(32'h118, 1, 0, "R9");
    send(32'h11C, 1, 0, "R9");
    send(32'h118, 1, 1, "R9");
    drain("R9");
    // Stalled handshake (R7)
    stall_en = 1;
    send(32'h904, 4, 0, "R7");
    send(32'hA1C, 4, 1, "R7");
    send(32'hB0C, 2, 0, "R7");
    send(32'hC00, 1, 1, "R7");
    drain("R7");
    stall_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule